// File: doc/BRIEF.md
# Writable 16-bit Event Timer

This block is a 16-bit up-counter built from two byte lanes. It counts rising edges of an increment level that a prescaler elsewhere produces and that reaches this block already synchronized to `clk`. A byte-wide register bus reads and writes the two count bytes and a control byte. The control byte holds a run enable and a sticky overflow flag, and the flag also drives an interrupt line.

The block sets an exact rule for how a bus write meets the increment level, so that no count is lost and none is doubled. A byte write replaces only the byte it addresses and never produces a carry into the other byte. A write made while the increment level is low also arms a guard. The guard makes the block skip the next rising edge, and it is released only by a falling edge. The block detects edges by comparing the level between cycles, so the high and low phases may have any length.

Register map: address 0 is the low count byte and address 1 is the high count byte. Address 2 is control: bit 0 is run, and bit 1 is the overflow flag, which is cleared by writing a 1 to it. Address 3 reads as zero.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count is 00:00, run and the overflow flag are 0, `irq_o` is low, and address 3 reads 0x00.
- R2: While run (control bit 0) is 1, each low-to-high change of `inc_lvl_i` adds one to the count, once per change, however long the level then stays high.
- R3: While run is 0, changes of `inc_lvl_i` leave the count unchanged.
- R4: A write to address 0 or 1 made while `inc_lvl_i` is high lets the next rising edge count normally.
- R5: A write to address 0 or 1 made while `inc_lvl_i` is low makes the block ignore the next rising edge. Counting resumes at the first rising edge that follows a falling edge.
- R6: Writing the high byte (address 1) leaves the low byte unchanged. For example, 3F:00 rewritten at the high byte stays 3F:00.
- R7: Writing the low byte (address 0) when the count is xx:FF causes no carry into the high byte.
- R8: A counted step from FF:FF to 00:00 sets the overflow flag (control bit 1) and `irq_o`. Both stay set until a control write has bit 1 = 1. A control write with bit 1 = 0 leaves them set.
- R9: Writing 0x00 to the low byte when the count is FF:FF gives FF:00 and does not set the overflow flag.
- R10: When a byte write and a counted rising edge fall in the same cycle, the written value is kept and no increment is applied in that cycle.
- R11: When a counted rollover and a control write that clears the flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| inc_lvl_i | input | 1 | Synchronized increment level from the prescaler |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 2 | Register address (0 low, 1 high, 2 control) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational from the registers |
| irq_o | output | 1 | Overflow flag |

## Verification
Every result here is registered once. A rising level or a write that is sampled at edge k changes the count and the flag at edge k. Because the read path is combinational, `bus_rdata_o` and `irq_o` show the new value during the cycle after edge k. Before sampling a result, the bench therefore drives each stimulus half a period ahead of an edge and then waits for one full edge. A behavioural model in the bench advances at every rising clock edge, and the bench compares the addressed byte and `irq_o` with it one nanosecond before the next edge. Directed reads with fixed expected values cover the guard, write isolation and rollover cases.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // Default geometry of the counter and bus
  localparam int unsigned EVT_LANE_W = 8;
  localparam int unsigned EVT_LANES  = 2;
  localparam int unsigned EVT_ADDR_W = 2;
  // Control byte fields
  localparam int unsigned CTL_RUN_BIT = 0;
  localparam int unsigned CTL_OVF_BIT = 1;

  typedef struct packed {
    logic run;
    logic ovf;
  } evt_ctl_t;
endpackage

// File: rtl/evt_edge_gate.sv
// Detects edges of the increment level and keeps the post-write guard.
module evt_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic byte_wr_i,
  output logic rise_o,
  output logic fall_o,
  output logic blocked_o
);
  logic lvl_q;
  logic blk_q, blk_d;

  always_comb begin
    rise_o = lvl_i & ~lvl_q;
    fall_o = ~lvl_i & lvl_q;
    blk_d  = blk_q;
    if (byte_wr_i && !lvl_i) begin
      blk_d = 1'b1;          // a write during the low phase skips the next rise
    end else if (fall_o) begin
      blk_d = 1'b0;          // a full low phase re-enables counting
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      blk_q <= blk_d;
    end
  end

  assign blocked_o = blk_q;
endmodule

// File: rtl/evt_byte_counter.sv
// Counter built from independent byte lanes; each lane loads on its own write.
module evt_byte_counter #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_i,
  input  logic [LANES-1:0]         lane_wr_i,
  input  logic [LANE_W-1:0]        wdata_i,
  output logic [LANE_W*LANES-1:0]  cnt_o,
  output logic                     wrap_o
);
  logic [LANES-1:0] full;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] q, d;
    logic              carry_in;
    logic              ce;

    if (g == 0) begin : g_first
      assign carry_in = step_i;
    end else begin : g_upper
      assign carry_in = step_i & (&full[g-1:0]);
    end

    always_comb begin
      ce = lane_wr_i[g] | carry_in;
      d  = lane_wr_i[g] ? wdata_i : q + LANE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ce) begin
        q <= d;
      end
    end

    assign full[g] = &q;
    assign cnt_o[g*LANE_W +: LANE_W] = q;
  end

  assign wrap_o = step_i & (&full);
endmodule

// File: rtl/evt_ctl_regs.sv
// Address decode, run enable and sticky overflow flag.
module evt_ctl_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              wrap_i,
  output logic [LANES-1:0]  lane_wr_o,
  output evt_ctl_t          ctl_o
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(LANES);

  evt_ctl_t ctl_q, ctl_d;
  logic     ctl_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    assign lane_wr_o[g] = wr_i && (addr_i == ADDR_W'(g));
  end

  always_comb begin
    ctl_wr = wr_i && (addr_i == CTL_ADDR);
    ctl_d  = ctl_q;
    if (ctl_wr) begin
      ctl_d.run = wdata_i[CTL_RUN_BIT];
    end
    if (wrap_i) begin
      ctl_d.ovf = 1'b1;                       // set has priority
    end else if (ctl_wr && wdata_i[CTL_OVF_BIT]) begin
      ctl_d.ovf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer_pkg::*;
#(
  parameter int unsigned LANE_W = EVT_LANE_W,
  parameter int unsigned LANES  = EVT_LANES,
  parameter int unsigned ADDR_W = EVT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_lvl_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LANE_W-1:0] bus_wdata_i,
  output logic [LANE_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = LANE_W * LANES;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [LANES-1:0] lane_wr_w;
  logic             byte_wr_w;
  logic             rise_w, fall_w, blocked_w;
  logic             step_w, wrap_w;
  logic [CNT_W-1:0] cnt_w;
  evt_ctl_t         ctl_w;
  logic             run_w, ovf_w;

  assign byte_wr_w = |lane_wr_w;
  assign run_w     = ctl_w.run;
  assign ovf_w     = ctl_w.ovf;
  // A byte write takes the cycle: no step while any lane loads
  assign step_w    = rise_w & run_w & ~blocked_w & ~byte_wr_w;

  evt_edge_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lvl_i     (inc_lvl_i),
    .byte_wr_i (byte_wr_w),
    .rise_o    (rise_w),
    .fall_o    (fall_w),
    .blocked_o (blocked_w)
  );

  evt_byte_counter #(.LANE_W(LANE_W), .LANES(LANES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_i    (step_w),
    .lane_wr_i (lane_wr_w),
    .wdata_i   (bus_wdata_i),
    .cnt_o     (cnt_w),
    .wrap_o    (wrap_w)
  );

  evt_ctl_regs #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .wrap_i    (wrap_w),
    .lane_wr_o (lane_wr_w),
    .ctl_o     (ctl_w)
  );

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (bus_addr_i == ADDR_W'(i)) begin
        bus_rdata_o = cnt_w[i*LANE_W +: LANE_W];
      end
    end
    if (bus_addr_i == ADDR_W'(LANES)) begin
      bus_rdata_o[CTL_RUN_BIT] = run_w;
      bus_rdata_o[CTL_OVF_BIT] = ovf_w;
    end
  end

  assign irq_o = ovf_w;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [LANE_W-1:0] bus_wdata_i,
  input logic              rise,
  input logic              blocked,
  input logic              run,
  input logic              ovf,
  input logic [CNT_W-1:0]  cnt
);
  localparam int unsigned LANES = CNT_W / LANE_W;

  logic lo_wr, hi_wr, byte_wr, flag_clr;
  assign lo_wr    = bus_wr_i && (bus_addr_i == ADDR_W'(0));
  assign hi_wr    = bus_wr_i && (bus_addr_i == ADDR_W'(1));
  assign byte_wr  = bus_wr_i && (bus_addr_i < ADDR_W'(LANES));
  assign flag_clr = bus_wr_i && (bus_addr_i == ADDR_W'(LANES)) && bus_wdata_i[1];

  a_r2_counted_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && rise && !blocked && !byte_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!run && !byte_wr) |=> $stable(cnt));

  a_r5_guarded_rise: assert property (@(posedge clk) disable iff (!rst_ok)
    (blocked && rise && !byte_wr) |=> $stable(cnt));

  a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_ok)
    hi_wr |=> (cnt[LANE_W-1:0] == $past(cnt[LANE_W-1:0])));

  a_r7_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_ok)
    lo_wr |=> (cnt[2*LANE_W-1:LANE_W] == $past(cnt[2*LANE_W-1:LANE_W])));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    (ovf && !flag_clr) |=> ovf);

  a_r9_write_no_flag: assert property (@(posedge clk) disable iff (!rst_ok)
    byte_wr |=> $stable(ovf));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    lo_wr |=> (cnt[LANE_W-1:0] == $past(bus_wdata_i)));
endmodule

bind evt_timer16 evt_timer16_chk #(.LANE_W(LANE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .rise        (rise_w),
  .blocked     (blocked_w),
  .run         (run_w),
  .ovf         (ovf_w),
  .cnt         (cnt_w)
);

// File: tb/evt_timer16_tb.sv
`timescale 1ns/1ps
module evt_timer16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_lvl = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  evt_timer16 u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_lvl_i   (inc_lvl),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  // Behavioural reference model
  int m_cnt, m_run, m_ovf, m_guard, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_ovf = 0; m_guard = 0; m_prev = 0;
    end else begin
      bit up, down, bytew, wrapped;
      up      = inc_lvl && !m_prev;
      down    = !inc_lvl && m_prev;
      bytew   = bus_wr && (bus_addr < 2);
      wrapped = 0;
      if (m_run != 0 && up && m_guard == 0 && !bytew) begin
        if (m_cnt == 65535) begin m_cnt = 0; wrapped = 1; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_cnt = (m_cnt / 256) * 256 + bus_wdata;
          2'd1: m_cnt = bus_wdata * 256 + (m_cnt % 256);
          2'd2: begin
            m_run = bus_wdata[0];
            if (bus_wdata[1] && !wrapped) m_ovf = 0;
          end
          default: ;
        endcase
      end
      if (bytew && !inc_lvl) m_guard = 1;
      else if (down) m_guard = 0;
      m_prev = inc_lvl;
    end
  end

  function automatic int model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt % 256;
      2'd1: return m_cnt / 256;
      2'd2: return m_run + 2 * m_ovf;
      default: return 0;
    endcase
  endfunction

  // Every-clock comparison, 1 ns before the rising edge
  always @(negedge clk) begin
    #4;
    if (rst_n && !done) begin
      n_checks++;
      if (int'(bus_rdata) != model_read(bus_addr) || int'(irq) != m_ovf) begin
        n_errs++;
        $display("FAIL R2 model compare addr=%0d: rdata=%02h irq=%0b expected rdata=%02h irq=%0d",
                 bus_addr, bus_rdata, irq, model_read(bus_addr), m_ovf);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lvl(input logic v);
    inc_lvl = v;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    n_checks++;
    if (bus_rdata !== exp) begin
      n_errs++;
      $display("FAIL %s addr=%0d: got %02h expected %02h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    n_checks++;
    if (irq !== exp) begin
      n_errs++;
      $display("FAIL %s irq: got %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_errs++;
      n_checks++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk_reg("R1", 2'd0, 8'h00);
    chk_reg("R1", 2'd1, 8'h00);
    chk_reg("R1", 2'd2, 8'h00);
    chk_reg("R1", 2'd3, 8'h00);
    chk_irq("R1", 1'b0);

    // R3 stopped: edges are not counted
    for (int i = 0; i < 3; i++) begin lvl(1); lvl(0); end
    chk_reg("R3", 2'd0, 8'h00);

    // R2 running, uneven duty cycle
    wr(2'd2, 8'h01);
    for (int i = 0; i < 3; i++) begin lvl(1); tick(2); lvl(0); tick(1); end
    chk_reg("R2", 2'd0, 8'h03);
    lvl(1); tick(6);
    chk_reg("R2", 2'd0, 8'h04);

    // R4 write while level high
    wr(2'd0, 8'h10);
    lvl(0); lvl(1);
    chk_reg("R4", 2'd0, 8'h11);

    // R5 write while level low
    lvl(0);
    wr(2'd0, 8'h20);
    lvl(1);
    chk_reg("R5", 2'd0, 8'h20);
    lvl(0); lvl(1);
    chk_reg("R5", 2'd0, 8'h21);

    // R3 again after stopping
    wr(2'd2, 8'h00);
    lvl(0); lvl(1); lvl(0); lvl(1);
    chk_reg("R3", 2'd0, 8'h21);

    // R6 high-byte rewrite leaves low byte
    wr(2'd1, 8'h3F); wr(2'd0, 8'h00); wr(2'd1, 8'h3F);
    chk_reg("R6", 2'd0, 8'h00);
    chk_reg("R6", 2'd1, 8'h3F);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h7A); wr(2'd1, 8'h55);
    chk_reg("R6", 2'd0, 8'h7A);
    chk_reg("R6", 2'd1, 8'h55);

    // R7 low-byte writes at xx:FF do not carry
    wr(2'd1, 8'h12); wr(2'd0, 8'hFF); wr(2'd0, 8'hFF);
    chk_reg("R7", 2'd1, 8'h12);
    wr(2'd0, 8'h05);
    chk_reg("R7", 2'd1, 8'h12);
    chk_reg("R7", 2'd0, 8'h05);

    // R9 clearing the low byte from FF:FF
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF); wr(2'd0, 8'h00);
    chk_reg("R9", 2'd1, 8'hFF);
    chk_reg("R9", 2'd0, 8'h00);
    chk_reg("R9", 2'd2, 8'h01);
    chk_irq("R9", 1'b0);

    // R8 counted rollover sets a sticky flag
    wr(2'd0, 8'hFF);
    lvl(0); lvl(1);
    chk_reg("R8", 2'd0, 8'h00);
    chk_reg("R8", 2'd1, 8'h00);
    chk_reg("R8", 2'd2, 8'h03);
    chk_irq("R8", 1'b1);
    tick(5);
    chk_irq("R8", 1'b1);
    wr(2'd2, 8'h01);
    chk_reg("R8", 2'd2, 8'h03);
    wr(2'd2, 8'h03);
    chk_reg("R8", 2'd2, 8'h01);
    chk_irq("R8", 1'b0);

    // R10 write coincides with a rising edge
    lvl(0);
    inc_lvl = 1'b1;
    wr(2'd0, 8'h40);
    chk_reg("R10", 2'd0, 8'h40);
    lvl(0); lvl(1);
    chk_reg("R10", 2'd0, 8'h41);

    // R11 rollover and flag clear in the same cycle
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    lvl(0);
    inc_lvl = 1'b1;
    wr(2'd2, 8'h03);
    chk_reg("R11", 2'd2, 8'h03);
    chk_reg("R11", 2'd0, 8'h00);
    chk_irq("R11", 1'b1);

    tick(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule